// File: doc/BRIEF.md
# Banked Register File with Indirect Pointer

This block is the byte-wide data register file of a small processor core. It holds two banks of 128 locations each. The low offsets of every bank hold special registers and the high offsets hold general-purpose RAM. Four special registers exist once and answer at the same offset in both banks: the low program-counter byte, the status byte, the pointer and the program-counter latch. Every other location is private to its bank.

An access names a 7-bit offset. In direct mode the bank comes from the bank-select field of the status byte. Offset 00h has no storage behind it. Naming it, or raising the indirect-mode input, routes the access through the 8-bit pointer, and the pointer then supplies both the bank and the offset. A pointer that lands back on offset 00h of either bank reads as zero and absorbs writes. The status byte's upper bank bit selects a bank pair that does not exist, so while it is set, pointer accesses find no storage.

Reads are combinational. Writes land on the rising clock edge while write enable is high. The pointer and the status bank bits are driven out for the decoder and other logic.

Top module: `bankreg_file`

## Requirements
- R1: A synchronous active-low reset clears the four shared special registers (low program-counter byte at 02h, status at 03h, pointer at 04h, latch at 0Ah), so ptr_o, bank_dir_o and bank_ind_o read 0 after reset.
- R2: In direct mode, status bit 5 alone picks the bank (0 gives bank 0, 1 gives bank 1). Status bit 6 is ignored, so codes 10 and 11 reach bank 0 and bank 1 respectively and never any further storage.
- R3: General-purpose locations at the same offset in bank 0 and bank 1 are separate cells.
- R4: Offsets 02h, 03h, 04h and 0Ah name one physical cell each, which is reachable from either bank.
- R5: When ind_i is 1, or when the direct offset is 00h, the access goes to the full address held in the pointer. Pointer bit 7 is the bank and bits 6:0 are the offset, and addr_i is not used.
- R6: A pointer access whose target offset is 00h (pointer 00h or 80h) reads 00h.
- R7: A pointer write whose target offset is 00h stores nothing.
- R8: While status bit 7 is 1, a pointer access reads 00h and its write stores nothing.
- R9: A write takes effect on the rising clock edge only while we_i is 1. With we_i at 0, no cell changes.
- R10: rdata_o shows the selected cell within the same cycle in which the address is applied.
- R11: ptr_o mirrors the pointer cell, bank_dir_o mirrors status bits 6:5 and bank_ind_o mirrors status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 7 | Direct offset within the bank |
| ind_i | input | 1 | 1 forces access through the pointer |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| ptr_o | output | 8 | Current pointer value |
| bank_dir_o | output | 2 | Status bank-select field for direct mode |
| bank_ind_o | output | 1 | Status upper bank bit for pointer mode |

## Verification
The bench builds the block with its default parameters: 8-bit data, 7-bit offsets and two banks. With these values the pointer is exactly one bank bit plus one offset. That puts both self-referencing pointer values (00h and 80h) within reach, as well as the status codes 10 and 11 that must fold onto the two real banks. A scoreboard stores the same general offset in both banks, walks the shared registers across banks and moves the pointer through each bank. It then confirms that discarded writes left the pointer, the status byte and the RAM untouched.

// File: rtl/rf_pkg.sv
// Package rf_pkg
// Shared constants, the shared-register map and the access-target record for
// the banked register file. Assumes the pointer is exactly bank bits plus
// offset bits wide.
package rf_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned OFF_W      = 7;
    localparam int unsigned NUM_BANKS  = 2;
    localparam int unsigned BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int unsigned SHARED_CNT = 4;
    localparam int unsigned SHIDX_W    = $clog2(SHARED_CNT);

    // Offset with no storage: accesses there go through the pointer
    localparam logic [OFF_W-1:0] OFF_VIRTUAL = '0;

    // Offsets that map to one physical cell in every bank
    localparam logic [OFF_W-1:0] SHARED_OFFS [SHARED_CNT] =
        '{7'h02, 7'h03, 7'h04, 7'h0A};

    // Positions in the shared-cell array
    localparam int unsigned IDX_STATUS  = 1;
    localparam int unsigned IDX_POINTER = 2;

    // Status byte fields
    localparam int unsigned ST_BANK_LO = 5;
    localparam int unsigned ST_BANK_HI = 6;
    localparam int unsigned ST_PAIR    = 7;

    typedef struct packed {
        logic               hit;       // storage exists behind the target
        logic               self_ref;  // pointer lands on the virtual offset
        logic               pair_miss; // upper bank bit set on a pointer access
        logic               via_ptr;   // access routed through the pointer
        logic [BANK_W-1:0]  bank;
        logic [OFF_W-1:0]   off;
        logic               shared;
        logic [SHIDX_W-1:0] sh_idx;
    } rf_target_t;

    // True when the offset names a cell shared by all banks
    function automatic logic is_shared(input logic [OFF_W-1:0] off);
        logic found;
        found = 1'b0;
        for (int i = 0; i < SHARED_CNT; i++) begin
            if (off == SHARED_OFFS[i]) found = 1'b1;
        end
        return found;
    endfunction

    // Position of a shared offset in the shared-cell array
    function automatic logic [SHIDX_W-1:0] shared_index(input logic [OFF_W-1:0] off);
        logic [SHIDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < SHARED_CNT; i++) begin
            if (off == SHARED_OFFS[i]) idx = SHIDX_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/rf_addr_resolve.sv
// Module rf_addr_resolve
// Turns an offset, the mode input, the pointer and the status byte into one
// access target. Purely combinational. Assumes that the pointer supplies bank
// and offset together and that the status upper bank bit must stay 0.
module rf_addr_resolve
    import rf_pkg::*;
#(
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_OFF_W  = OFF_W
) (
    input  logic [P_OFF_W-1:0]  addr_i,
    input  logic                ind_i,
    input  logic [P_DATA_W-1:0] ptr_i,
    input  logic [P_DATA_W-1:0] status_i,
    output rf_target_t          tgt_o
);

    localparam int unsigned FULL_W = BANK_W + P_OFF_W;

    logic              use_ptr;
    logic [FULL_W-1:0] full_addr;

    // Choose between direct bank plus offset and the pointer contents
    always_comb begin
        use_ptr = ind_i || (addr_i == OFF_VIRTUAL);
        if (use_ptr) begin
            full_addr = ptr_i[FULL_W-1:0];
        end else begin
            full_addr = {status_i[ST_BANK_LO +: BANK_W], addr_i};
        end
    end

    // Classify the resolved address
    always_comb begin
        tgt_o.via_ptr   = use_ptr;
        tgt_o.bank      = full_addr[FULL_W-1 -: BANK_W];
        tgt_o.off       = full_addr[P_OFF_W-1:0];
        tgt_o.pair_miss = use_ptr && status_i[ST_PAIR];
        tgt_o.self_ref  = use_ptr && (full_addr[P_OFF_W-1:0] == OFF_VIRTUAL);
        tgt_o.hit       = !tgt_o.pair_miss && !tgt_o.self_ref;
        tgt_o.shared    = is_shared(full_addr[P_OFF_W-1:0]);
        tgt_o.sh_idx    = shared_index(full_addr[P_OFF_W-1:0]);
    end

endmodule

// File: rtl/rf_shared_regs.sv
// Module rf_shared_regs
// Holds the special registers that answer at the same offset in every bank.
// Each cell has a synchronous active-low reset to zero. Assumes that at most
// one cell is written per cycle.
module rf_shared_regs
    import rf_pkg::*;
#(
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_CNT    = SHARED_CNT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [SHIDX_W-1:0]            wr_idx_i,
    input  logic [P_DATA_W-1:0]           wr_data_i,
    output logic [P_CNT-1:0][P_DATA_W-1:0] cells_o
);

    logic [P_CNT-1:0][P_DATA_W-1:0] cell_q;

    for (genvar g = 0; g < P_CNT; g++) begin : g_cell
        // Reset or load one shared cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == SHIDX_W'(g))) begin
                cell_q[g] <= wr_data_i;
            end
        end
    end

    assign cells_o = cell_q;

    // R9: without a write strobe no shared cell moves
    p_shared_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(cell_q));

endmodule

// File: rtl/rf_bank_store.sv
// Module rf_bank_store
// Storage private to one bank: general RAM and the unshared special offsets.
// There is no reset; contents are undefined until written. Assumes the
// caller never writes the virtual offset or a shared offset.
module rf_bank_store
    import rf_pkg::*;
#(
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_OFF_W  = OFF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [P_OFF_W-1:0]  wr_off_i,
    input  logic [P_DATA_W-1:0] wr_data_i,
    input  logic [P_OFF_W-1:0]  rd_off_i,
    output logic [P_DATA_W-1:0] rd_data_o
);

    localparam int unsigned DEPTH = 1 << P_OFF_W;

    logic [P_DATA_W-1:0] mem [DEPTH];

    // Store a byte on the clock edge
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_off_i] <= wr_data_i;
        end
    end

    // Combinational read of the addressed byte
    assign rd_data_o = mem[rd_off_i];

    // R7: the virtual offset never receives a write
    p_no_virtual_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_off_i != OFF_VIRTUAL));

    // R4: shared offsets never land in private storage
    p_shared_not_banked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> !is_shared(wr_off_i));

endmodule

// File: rtl/bankreg_file.sv
// Module bankreg_file
// Two-bank byte register file with a pointer-based indirect path. It resolves
// every access, steers writes to the shared cells or to one bank, and muxes
// the combinational read. Assumes one access per cycle.
module bankreg_file
    import rf_pkg::*;
#(
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_OFF_W  = OFF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_OFF_W-1:0]  addr_i,
    input  logic                ind_i,
    input  logic                we_i,
    input  logic [P_DATA_W-1:0] wdata_i,
    output logic [P_DATA_W-1:0] rdata_o,
    output logic [P_DATA_W-1:0] ptr_o,
    output logic [1:0]          bank_dir_o,
    output logic                bank_ind_o
);

    rf_target_t                            tgt;
    logic [SHARED_CNT-1:0][P_DATA_W-1:0]   sh_cells;
    logic [NUM_BANKS-1:0][P_DATA_W-1:0]    bank_rd;
    logic [NUM_BANKS-1:0]                  bank_we;
    logic                                  sh_we;
    logic [P_DATA_W-1:0]                   status_val;

    assign ptr_o      = sh_cells[IDX_POINTER];
    assign status_val = sh_cells[IDX_STATUS];
    assign bank_dir_o = status_val[ST_BANK_HI:ST_BANK_LO];
    assign bank_ind_o = status_val[ST_PAIR];

    rf_addr_resolve #(.P_DATA_W(P_DATA_W), .P_OFF_W(P_OFF_W)) u_resolve (
        .addr_i   (addr_i),
        .ind_i    (ind_i),
        .ptr_i    (ptr_o),
        .status_i (status_val),
        .tgt_o    (tgt)
    );

    // Route a write to the shared cells when the target is shared
    assign sh_we = we_i && tgt.hit && tgt.shared;

    rf_shared_regs #(.P_DATA_W(P_DATA_W), .P_CNT(SHARED_CNT)) u_shared (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (sh_we),
        .wr_idx_i  (tgt.sh_idx),
        .wr_data_i (wdata_i),
        .cells_o   (sh_cells)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Route a write to this bank's private storage
        assign bank_we[b] = we_i && tgt.hit && !tgt.shared &&
                            (tgt.bank == BANK_W'(b));

        rf_bank_store #(.P_DATA_W(P_DATA_W), .P_OFF_W(P_OFF_W)) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (bank_we[b]),
            .wr_off_i  (tgt.off),
            .wr_data_i (wdata_i),
            .rd_off_i  (tgt.off),
            .rd_data_o (bank_rd[b])
        );
    end

    // Select the read source; missing storage reads as zero
    always_comb begin
        if (!tgt.hit) begin
            rdata_o = '0;
        end else if (tgt.shared) begin
            rdata_o = sh_cells[tgt.sh_idx];
        end else begin
            rdata_o = bank_rd[tgt.bank];
        end
    end

    // R1: the first cycle after reset shows cleared pointer and status bits
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ptr_o == '0 && bank_dir_o == 2'b00 && !bank_ind_o));

    // R6: a self-referencing pointer reads zero
    p_self_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt.self_ref |-> (rdata_o == '0));

    // R8: the missing bank pair reads zero and accepts no write
    p_pair_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt.via_ptr && bank_ind_o) |-> (rdata_o == '0 && bank_we == '0 && !sh_we));

    // R7: a discarded self write leaves the pointer as it was
    p_self_write_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && tgt.self_ref) |=> $stable(ptr_o));

endmodule

// File: tb/bankreg_file_tb_top.sv
// Scoreboard bench for bankreg_file: driver tasks queue expected values,
// a monitor compares them against the outputs mid-cycle.
module bankreg_file_tb_top;

    localparam time CLK_HALF  = 10ns;
    localparam int  WATCHDOG  = 20000;

    typedef struct {
        int         kind;  // 0 rdata, 1 ptr, 2 bank_dir, 3 bank_ind
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr_i = '0;
    logic       ind_i = 1'b0;
    logic       we_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic [7:0] ptr_o;
    logic [1:0] bank_dir_o;
    logic       bank_ind_o;

    sb_item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #CLK_HALF clk = ~clk;

    bankreg_file dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ind_i(ind_i),
        .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ptr_o(ptr_o),
        .bank_dir_o(bank_dir_o), .bank_ind_o(bank_ind_o)
    );

    task automatic wr(input logic [6:0] a, input logic ind, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; ind_i = ind; wdata_i = d; we_i = 1'b1;
        @(negedge clk);
        we_i = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic ind, input logic [7:0] e, input string req);
        sb_item_t it;
        @(negedge clk);
        addr_i = a; ind_i = ind; we_i = 1'b0;
        it.kind = 0; it.exp = e; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic chk_out(input int kind, input logic [7:0] e, input string req);
        sb_item_t it;
        @(negedge clk);
        it.kind = kind; it.exp = e; it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare queued expectations half a phase after the driver
    initial begin
        forever begin
            @(negedge clk);
            #5ns;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0: act = rdata_o;
                    1: act = ptr_o;
                    2: act = {6'b0, bank_dir_o};
                    default: act = {7'b0, bank_ind_o};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind %0d actual %02h expected %02h",
                             it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_out(1, 8'h00, "R1 ptr");
        chk_out(2, 8'h00, "R1 bank_dir");
        chk_out(3, 8'h00, "R1 bank_ind");
        rd(7'h03, 1'b0, 8'h00, "R1 status");
        // R10 combinational read, R9 write on edge
        wr(7'h20, 1'b0, 8'hA5);
        rd(7'h20, 1'b0, 8'hA5, "R10 bank0 read");
        // R3 separate banks
        wr(7'h03, 1'b0, 8'h20);
        chk_out(2, 8'h01, "R11 bank_dir 01");
        wr(7'h20, 1'b0, 8'h5A);
        rd(7'h20, 1'b0, 8'h5A, "R3 bank1 cell");
        wr(7'h03, 1'b0, 8'h00);
        rd(7'h20, 1'b0, 8'hA5, "R3 bank0 kept");
        // R2 upper code bit ignored
        wr(7'h03, 1'b0, 8'h40);
        rd(7'h20, 1'b0, 8'hA5, "R2 code 10");
        wr(7'h03, 1'b0, 8'h60);
        rd(7'h20, 1'b0, 8'h5A, "R2 code 11");
        chk_out(2, 8'h03, "R11 bank_dir 11");
        // R4 shared cells
        wr(7'h0A, 1'b0, 8'h13);
        wr(7'h03, 1'b0, 8'h00);
        rd(7'h0A, 1'b0, 8'h13, "R4 latch across banks");
        rd(7'h03, 1'b0, 8'h00, "R4 status across banks");
        // R5 pointer access
        wr(7'h04, 1'b0, 8'hA0);
        chk_out(1, 8'hA0, "R11 ptr");
        rd(7'h00, 1'b0, 8'h5A, "R5 offset 00 via ptr");
        wr(7'h55, 1'b1, 8'h77);
        rd(7'h11, 1'b1, 8'h77, "R5 ind mode read");
        rd(7'h20, 1'b0, 8'hA5, "R5 bank0 untouched");
        wr(7'h03, 1'b0, 8'h20);
        rd(7'h20, 1'b0, 8'h77, "R5 bank1 written");
        wr(7'h03, 1'b0, 8'h00);
        // R9 no write without enable
        @(negedge clk);
        addr_i = 7'h20; ind_i = 1'b0; wdata_i = 8'hFF; we_i = 1'b0;
        @(negedge clk);
        rd(7'h20, 1'b0, 8'hA5, "R9 we low");
        // R6 self reference reads zero
        wr(7'h04, 1'b0, 8'h00);
        rd(7'h00, 1'b1, 8'h00, "R6 ptr 00");
        wr(7'h04, 1'b0, 8'h80);
        rd(7'h00, 1'b1, 8'h00, "R6 ptr 80");
        // R7 self write discarded
        wr(7'h04, 1'b0, 8'h00);
        wr(7'h00, 1'b1, 8'h99);
        chk_out(1, 8'h00, "R7 ptr kept");
        rd(7'h03, 1'b0, 8'h00, "R7 status kept");
        rd(7'h20, 1'b0, 8'hA5, "R7 ram kept");
        // R8 missing bank pair
        wr(7'h03, 1'b0, 8'h80);
        chk_out(3, 8'h01, "R11 bank_ind");
        wr(7'h04, 1'b0, 8'h20);
        rd(7'h00, 1'b1, 8'h00, "R8 read blocked");
        wr(7'h00, 1'b1, 8'h11);
        wr(7'h03, 1'b0, 8'h00);
        rd(7'h20, 1'b0, 8'hA5, "R8 write blocked");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule